// File: doc/BRIEF.md
# Latched Video Pixel Shifter

This block turns a 32-bit pixel word and a 32-bit palette word into a stream of 8-bit colour values. Its pace is set by two programmable counts: clocks per pixel and clocks per frame. A host offers new pixel and palette data through a ready/valid write port. One pending buffer holds that data. The shifter takes it into its working registers only at a frame boundary, so a second write stalls until the current frame has ended. The moment that write completes therefore marks the end of the previous frame.

A configuration write sets three things: an enable bit, a pixel mode and an output group. The mode is either 1 bit per pixel or 2 bits per pixel. The group picks one of four byte lanes on a 32-bit pin bus, and output enables follow the selected lane. Configuration takes effect on the next clock, even in the middle of a pixel. New timing values are different: they wait in a pending register until the next frame latch.

Two state machines control the block. The sequencer has two states. It goes from SEQ_PAUSED to SEQ_SHIFTING on a configuration write with the enable bit set, and from SEQ_SHIFTING back to SEQ_PAUSED on a configuration write with the enable bit clear. The buffer also has two states. It goes from BUF_EMPTY to BUF_FULL when a write is accepted. It goes from BUF_FULL back to BUF_EMPTY on a frame latch.

Top module: `pixshift_top`

## Requirements
- R1: After reset, the sequencer is in SEQ_PAUSED and the buffer is in BUF_EMPTY. Colour, pins and output enables are all 0, `wr_ready_o` is 1, and the timing register holds 1 clock per pixel and 32 clocks per frame.
- R2: With P clocks per pixel and F clocks per frame, each frame lasts F enabled clocks and each pixel lasts P clocks, counted from the clock after the latch edge. If F is not a multiple of P, the last pixel of the frame is cut short. A programmed value of 0 means 256 for P and 4096 for F.
- R3: In 1-bit mode (`cfg_mode_i`=0), pixel bits are used from bit 0 upward. Each bit selects palette byte 0 or 1. Palette byte k sits in `wr_palette_i[8k+7:8k]`.
- R4: In 2-bit mode (`cfg_mode_i`=1), pixels are taken two bits at a time, starting with bits [1:0]. Each pair selects one of the four palette bytes.
- R5: Zeros are shifted in as the pixel word empties. Every pixel after the 32nd in 1-bit mode, or after the 16th in 2-bit mode, therefore shows palette byte 0.
- R6: `wr_ready_o` is high exactly in BUF_EMPTY. An accepted write moves the buffer to BUF_FULL. `wr_ready_o` then stays low until the next frame latch.
- R7: At the last enabled clock of a frame, the buffer contents move into the shifter and the buffer returns to BUF_EMPTY. If nothing was written, the stale buffer contents are latched again.
- R8: A timing write is held pending. It does not change the pixel length of the frame that is running, and it takes effect from the next frame latch onward.
- R9: A configuration write changes the mode, the group and the enable on the next clock, without restarting the current pixel or frame.
- R10: Clearing the enable freezes both counters and forces the colour and all output enables to 0. Setting it again resumes the same frame at the next pixel.
- R11: The colour appears on byte lane `cfg_grp_i` of `pins_o`, and `pins_oe_o` is 8'hFF on that lane only while shifting. All other lanes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Host offers pixel and palette data |
| wr_ready_o | output | 1 | Pending buffer can take a write |
| wr_pixels_i | input | 32 | Pixel word, LSB shown first |
| wr_palette_i | input | 32 | Four palette bytes |
| tim_we_i | input | 1 | Timing write strobe |
| tim_pix_i | input | 8 | Clocks per pixel (0 = 256) |
| tim_frame_i | input | 12 | Clocks per frame (0 = 4096) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable shifting |
| cfg_mode_i | input | 1 | 0: 1-bit pixels, 1: 2-bit pixels |
| cfg_grp_i | input | 2 | Output byte lane select |
| color_o | output | 8 | Current colour value |
| pins_o | output | 32 | Routed pin bus |
| pins_oe_o | output | 32 | Pin output enables |

## Verification
The checker watches the following on every cycle:
- that an accepted write drops ready;
- that ready stays low until a frame latch and rises at it;
- that a disable leaves the outputs dark and the counters frozen;
- that output enables cover exactly one lane and no pin is driven outside it.

The pixel order, the palette decoding in both modes and the run-out to palette byte 0 can only be shown by the bench's scenarios. The same is true of the deferred timing, stale relatching, resuming after a pause, and the exact cycles at which mid-frame routing and mode changes take effect.

// File: rtl/pixshift_pkg.sv
package pixshift_pkg;
    localparam int WORD_W  = 32;
    localparam int COLOR_W = 8;
    localparam int PIX_W   = 8;
    localparam int FRM_W   = 12;
    localparam int LANES   = 4;

    typedef enum logic {
        MODE_1BPP = 1'b0,
        MODE_2BPP = 1'b1
    } mode_e;

    typedef enum logic {
        SEQ_PAUSED   = 1'b0,
        SEQ_SHIFTING = 1'b1
    } seq_e;

    typedef enum logic {
        BUF_EMPTY = 1'b0,
        BUF_FULL  = 1'b1
    } buf_e;
endpackage

// File: rtl/pixshift_timer.sv
module pixshift_timer #(
    parameter int PIX_W = 8,
    parameter int FRM_W = 12
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           run_i,
    input  logic [PIX_W:0] frame_pix_i,
    input  logic [FRM_W:0] frame_len_i,
    input  logic [PIX_W:0] cur_pix_i,
    output logic           frame_end_o,
    output logic           pix_end_o
);
    logic [PIX_W:0] pix_left_q;
    logic [FRM_W:0] frm_left_q;

    assign frame_end_o = (frm_left_q == (FRM_W+1)'(1));
    assign pix_end_o   = (pix_left_q == (PIX_W+1)'(1));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pix_left_q <= (PIX_W+1)'(1);
            frm_left_q <= (FRM_W+1)'(1);
        end else if (run_i) begin
            if (frame_end_o) begin
                frm_left_q <= frame_len_i;
                pix_left_q <= frame_pix_i;
            end else begin
                frm_left_q <= frm_left_q - (FRM_W+1)'(1);
                pix_left_q <= pix_end_o ? cur_pix_i : pix_left_q - (PIX_W+1)'(1);
            end
        end
    end
endmodule

// File: rtl/pixshift_serializer.sv
module pixshift_serializer
    import pixshift_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int COLOR_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic               advance_i,
    input  mode_e              mode_i,
    input  logic [WORD_W-1:0]  pix_i,
    input  logic [WORD_W-1:0]  pal_i,
    output logic [COLOR_W-1:0] color_o
);
    localparam int ENTRIES = WORD_W / COLOR_W;
    localparam int SEL_W   = $clog2(ENTRIES);

    logic [WORD_W-1:0]  pix_q;
    logic [WORD_W-1:0]  pal_q;
    logic [SEL_W-1:0]   sel;
    logic [COLOR_W-1:0] entry [ENTRIES];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pix_q <= '0;
            pal_q <= '0;
        end else if (load_i) begin
            pix_q <= pix_i;
            pal_q <= pal_i;
        end else if (advance_i) begin
            if (mode_i == MODE_2BPP) pix_q <= {2'b00, pix_q[WORD_W-1:2]};
            else                     pix_q <= {1'b0, pix_q[WORD_W-1:1]};
        end
    end

    always_comb begin
        sel = '0;
        if (mode_i == MODE_2BPP) sel[1:0] = pix_q[1:0];
        else                     sel[0]   = pix_q[0];
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        assign entry[e] = pal_q[e*COLOR_W +: COLOR_W];
    end

    assign color_o = entry[sel];
endmodule

// File: rtl/pixshift_router.sv
module pixshift_router #(
    parameter int COLOR_W = 8,
    parameter int LANES   = 4,
    localparam int LANE_W = $clog2(LANES),
    localparam int PIN_W  = COLOR_W * LANES
) (
    input  logic               on_i,
    input  logic [LANE_W-1:0]  grp_i,
    input  logic [COLOR_W-1:0] color_i,
    output logic [PIN_W-1:0]   pins_o,
    output logic [PIN_W-1:0]   oe_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        assign hit = on_i && (grp_i == LANE_W'(g));
        assign pins_o[g*COLOR_W +: COLOR_W] = hit ? color_i : '0;
        assign oe_o[g*COLOR_W +: COLOR_W]   = {COLOR_W{hit}};
    end
endmodule

// File: rtl/pixshift_top.sv
module pixshift_top
    import pixshift_pkg::*;
#(
    parameter int WORD_W  = pixshift_pkg::WORD_W,
    parameter int COLOR_W = pixshift_pkg::COLOR_W,
    parameter int PIX_W   = pixshift_pkg::PIX_W,
    parameter int FRM_W   = pixshift_pkg::FRM_W,
    parameter int LANES   = pixshift_pkg::LANES,
    localparam int LANE_W = $clog2(LANES),
    localparam int PIN_W  = COLOR_W * LANES
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_valid_i,
    output logic               wr_ready_o,
    input  logic [WORD_W-1:0]  wr_pixels_i,
    input  logic [WORD_W-1:0]  wr_palette_i,
    input  logic               tim_we_i,
    input  logic [PIX_W-1:0]   tim_pix_i,
    input  logic [FRM_W-1:0]   tim_frame_i,
    input  logic               cfg_we_i,
    input  logic               cfg_en_i,
    input  logic               cfg_mode_i,
    input  logic [LANE_W-1:0]  cfg_grp_i,
    output logic [COLOR_W-1:0] color_o,
    output logic [PIN_W-1:0]   pins_o,
    output logic [PIN_W-1:0]   pins_oe_o
);
    seq_e seq_q, seq_d;
    buf_e buf_q, buf_d;

    logic [WORD_W-1:0]  buf_pix_q, buf_pal_q;
    logic [PIX_W-1:0]   pend_pix_q, act_pix_q;
    logic [FRM_W-1:0]   pend_frm_q;
    mode_e              mode_q;
    logic [LANE_W-1:0]  grp_q;

    logic               run, accept, frame_end, pix_end, latch, advance;
    logic [COLOR_W-1:0] ser_color;

    // State registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q <= SEQ_PAUSED;
            buf_q <= BUF_EMPTY;
        end else begin
            seq_q <= seq_d;
            buf_q <= buf_d;
        end
    end

    // Next-state logic
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            SEQ_PAUSED:   if (cfg_we_i && cfg_en_i)  seq_d = SEQ_SHIFTING;
            SEQ_SHIFTING: if (cfg_we_i && !cfg_en_i) seq_d = SEQ_PAUSED;
            default:      seq_d = SEQ_PAUSED;
        endcase
        buf_d = buf_q;
        unique case (buf_q)
            BUF_EMPTY: if (wr_valid_i) buf_d = BUF_FULL;
            BUF_FULL:  if (latch)      buf_d = BUF_EMPTY;
            default:   buf_d = BUF_EMPTY;
        endcase
    end

    // State-derived outputs and strobes
    always_comb begin
        run        = (seq_q == SEQ_SHIFTING);
        wr_ready_o = (buf_q == BUF_EMPTY);
        accept     = wr_valid_i && wr_ready_o;
        latch      = run && frame_end;
        advance    = run && !frame_end && pix_end;
        color_o    = run ? ser_color : '0;
    end

    // Pending data, timing and configuration registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            buf_pix_q  <= '0;
            buf_pal_q  <= '0;
            pend_pix_q <= PIX_W'(1);
            pend_frm_q <= FRM_W'(32);
            act_pix_q  <= PIX_W'(1);
            mode_q     <= MODE_1BPP;
            grp_q      <= '0;
        end else begin
            if (accept) begin
                buf_pix_q <= wr_pixels_i;
                buf_pal_q <= wr_palette_i;
            end
            if (tim_we_i) begin
                pend_pix_q <= tim_pix_i;
                pend_frm_q <= tim_frame_i;
            end
            if (latch) act_pix_q <= pend_pix_q;
            if (cfg_we_i) begin
                mode_q <= mode_e'(cfg_mode_i);
                grp_q  <= cfg_grp_i;
            end
        end
    end

    pixshift_timer #(.PIX_W(PIX_W), .FRM_W(FRM_W)) i_timer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run),
        .frame_pix_i ({pend_pix_q == '0, pend_pix_q}),
        .frame_len_i ({pend_frm_q == '0, pend_frm_q}),
        .cur_pix_i   ({act_pix_q == '0, act_pix_q}),
        .frame_end_o (frame_end),
        .pix_end_o   (pix_end)
    );

    pixshift_serializer #(.WORD_W(WORD_W), .COLOR_W(COLOR_W)) i_ser (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (latch),
        .advance_i (advance),
        .mode_i    (mode_q),
        .pix_i     (buf_pix_q),
        .pal_i     (buf_pal_q),
        .color_o   (ser_color)
    );

    pixshift_router #(.COLOR_W(COLOR_W), .LANES(LANES)) i_router (
        .on_i    (run),
        .grp_i   (grp_q),
        .color_i (ser_color),
        .pins_o  (pins_o),
        .oe_o    (pins_oe_o)
    );
endmodule

// File: rtl/pixshift_chk.sv
module pixshift_chk #(
    parameter int COLOR_W = 8,
    parameter int PIN_W   = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               wr_valid_i,
    input logic               wr_ready_o,
    input logic               cfg_we_i,
    input logic               cfg_en_i,
    input logic [COLOR_W-1:0] color_o,
    input logic [PIN_W-1:0]   pins_o,
    input logic [PIN_W-1:0]   pins_oe_o,
    input logic               run,
    input logic               frame_end,
    input logic               pix_end
);
    AST_ACCEPT_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_i && wr_ready_o |=> !wr_ready_o); // R6

    AST_STALL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_ready_o && !(run && frame_end) |=> !wr_ready_o); // R6

    AST_LATCH_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_ready_o && run && frame_end |=> wr_ready_o); // R7

    AST_DISABLE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we_i && !cfg_en_i |=> (color_o == '0) && (pins_oe_o == '0)); // R10

    AST_PAUSE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run |=> $stable(frame_end) && $stable(pix_end)); // R10

    AST_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(pins_oe_o) == 0) || ($countones(pins_oe_o) == COLOR_W)); // R11

    AST_NO_STRAY_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pins_o & ~pins_oe_o) == '0); // R11
endmodule

bind pixshift_top pixshift_chk #(.COLOR_W(COLOR_W), .PIN_W(PIN_W)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_ready_o (wr_ready_o),
    .cfg_we_i   (cfg_we_i),
    .cfg_en_i   (cfg_en_i),
    .color_o    (color_o),
    .pins_o     (pins_o),
    .pins_oe_o  (pins_oe_o),
    .run        (run),
    .frame_end  (frame_end),
    .pix_end    (pix_end)
);

// File: tb/test_pixshift_top.sv
module test_pixshift_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_pix = '0, wr_pal = '0;
    logic        tim_we = 1'b0;
    logic [7:0]  tim_pix = '0;
    logic [11:0] tim_frm = '0;
    logic        cfg_we = 1'b0, cfg_en = 1'b0, cfg_mode = 1'b0;
    logic [1:0]  cfg_grp = '0;
    logic [7:0]  color;
    logic [31:0] pins, pins_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pixshift_top i_pixshift_top (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
        .wr_pixels_i(wr_pix), .wr_palette_i(wr_pal),
        .tim_we_i(tim_we), .tim_pix_i(tim_pix), .tim_frame_i(tim_frm),
        .cfg_we_i(cfg_we), .cfg_en_i(cfg_en), .cfg_mode_i(cfg_mode), .cfg_grp_i(cfg_grp),
        .color_o(color), .pins_o(pins), .pins_oe_o(pins_oe)
    );

    typedef struct packed {
        logic [2:0]  tag;
        logic        mode;
        logic [7:0]  p;
        logic [11:0] f;
        logic [31:0] pix;
        logic [12:0] c;
        logic [7:0]  exp;
    } vec_t;

    localparam logic [31:0] PAL = 32'h4433_2211;
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd3, 1'b0, 8'd1, 12'd32, 32'h0000_0002, 13'd0,   8'h11}, // R3
        '{3'd3, 1'b0, 8'd1, 12'd32, 32'h0000_0002, 13'd1,   8'h22}, // R3
        '{3'd4, 1'b1, 8'd2, 12'd32, 32'h0000_00E4, 13'd5,   8'h33}, // R4
        '{3'd4, 1'b1, 8'd2, 12'd32, 32'h0000_00E4, 13'd7,   8'h44}, // R4
        '{3'd5, 1'b0, 8'd1, 12'd40, 32'hFFFF_FFFF, 13'd31,  8'h22}, // R5
        '{3'd5, 1'b0, 8'd1, 12'd40, 32'hFFFF_FFFF, 13'd32,  8'h11}, // R5
        '{3'd5, 1'b1, 8'd1, 12'd20, 32'hFFFF_FFFF, 13'd15,  8'h44}, // R5
        '{3'd5, 1'b1, 8'd1, 12'd20, 32'hFFFF_FFFF, 13'd16,  8'h11}, // R5
        '{3'd2, 1'b0, 8'd0, 12'd0,  32'h0000_0002, 13'd255, 8'h11}, // R2
        '{3'd2, 1'b0, 8'd0, 12'd0,  32'h0000_0002, 13'd256, 8'h22}, // R2
        '{3'd2, 1'b0, 8'd3, 12'd7,  32'h0000_0004, 13'd6,   8'h22}, // R2
        '{3'd7, 1'b0, 8'd3, 12'd7,  32'h0000_0004, 13'd7,   8'h11}, // R7
        '{3'd7, 1'b0, 8'd3, 12'd7,  32'h0000_0004, 13'd13,  8'h22}  // R7
    };

    function automatic string tag_name(input logic [2:0] t);
        case (t)
            3'd2:    return "R2";
            3'd3:    return "R3";
            3'd4:    return "R4";
            3'd5:    return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_valid = 1'b0; tim_we = 1'b0; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_tim(input logic [7:0] p, input logic [11:0] f);
        tim_pix = p; tim_frm = f; tim_we = 1'b1;
        @(negedge clk);
        tim_we = 1'b0;
    endtask

    task automatic do_data(input logic [31:0] px, input logic [31:0] pl);
        wr_pix = px; wr_pal = pl; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_cfg(input logic en, input logic md, input logic [1:0] g);
        cfg_en = en; cfg_mode = md; cfg_grp = g; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 ready", {31'd0, wr_ready}, 32'd1);
        chk("R1 color", {24'd0, color}, 32'd0);
        chk("R1 oe", pins_oe, 32'd0);
        chk("R1 pins", pins, 32'd0);

        // Vector table: timing, modes, run-out, relatch
        for (int v = 0; v < NV; v++) begin
            do_reset();
            do_tim(VECS[v].p, VECS[v].f);
            do_data(VECS[v].pix, PAL);
            do_cfg(1'b1, VECS[v].mode, 2'd0);
            for (int k = 0; k <= int'(VECS[v].c); k++) @(negedge clk);
            chk(tag_name(VECS[v].tag), {24'd0, color}, {24'd0, VECS[v].exp});
        end

        // R1 default timing, R6 stall, R8 deferred timing, R7 latch
        do_reset();
        do_data(32'h0000_0002, 32'h0000_BBAA);
        chk("R6 full", {31'd0, wr_ready}, 32'd0);
        do_cfg(1'b1, 1'b0, 2'd0);
        wr_pix = 32'h0000_0002; wr_pal = 32'h0000_CC55; wr_valid = 1'b1;
        @(negedge clk); // c=0
        chk("R7 freed", {31'd0, wr_ready}, 32'd1);
        @(negedge clk); // c=1
        wr_valid = 1'b0;
        chk("R6 stalled", {31'd0, wr_ready}, 32'd0);
        chk("R1 pix1", {24'd0, color}, 32'h0000_00BB);
        @(negedge clk); // c=2
        chk("R1 pix2", {24'd0, color}, 32'h0000_00AA);
        @(negedge clk); // c=3
        do_tim(8'd2, 12'd8); // returns at c=4
        chk("R8 old pix", {24'd0, color}, 32'h0000_00AA);
        repeat (27) @(negedge clk); // c=31
        chk("R6 held", {31'd0, wr_ready}, 32'd0);
        chk("R1 frame len", {24'd0, color}, 32'h0000_00AA);
        @(negedge clk); // c=32
        chk("R7 ready", {31'd0, wr_ready}, 32'd1);
        chk("R7 new data", {24'd0, color}, 32'h0000_0055);
        @(negedge clk); // c=33
        chk("R8 new P", {24'd0, color}, 32'h0000_0055);
        @(negedge clk); // c=34
        chk("R8 pix1", {24'd0, color}, 32'h0000_00CC);

        // R10 pause and resume
        do_reset();
        do_data(32'h0000_0004, 32'h0000_BBAA);
        do_cfg(1'b1, 1'b0, 2'd0);
        @(negedge clk); // c=0
        @(negedge clk); // c=1
        chk("R10 running", {24'd0, color}, 32'h0000_00AA);
        do_cfg(1'b0, 1'b0, 2'd0);
        chk("R10 dark", {24'd0, color}, 32'd0);
        chk("R10 oe off", pins_oe, 32'd0);
        repeat (5) @(negedge clk);
        chk("R10 still dark", {24'd0, color}, 32'd0);
        do_cfg(1'b1, 1'b0, 2'd0);
        chk("R10 resume", {24'd0, color}, 32'h0000_00BB);
        @(negedge clk);
        chk("R10 next", {24'd0, color}, 32'h0000_00AA);

        // R11 routing and R9 instant configuration
        do_reset();
        do_data(32'hFFFF_FFFF, 32'h0000_7700);
        do_cfg(1'b1, 1'b0, 2'd0);
        @(negedge clk);
        chk("R11 lane0", pins, 32'h0000_0077);
        chk("R11 oe0", pins_oe, 32'h0000_00FF);
        do_cfg(1'b1, 1'b0, 2'd2);
        chk("R9 lane2", pins, 32'h0077_0000);
        chk("R11 oe2", pins_oe, 32'h00FF_0000);
        do_cfg(1'b1, 1'b0, 2'd3);
        chk("R11 lane3", pins, 32'h7700_0000);
        do_cfg(1'b1, 1'b1, 2'd3);
        chk("R9 mode", {24'd0, color}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule